// File: doc/BRIEF.md
# Dual-Bank Direct Digital Synthesizer Core

This core is a numerically controlled oscillator. It holds two 28-bit tuning words and two 12-bit phase offsets. On every clock it adds the selected tuning word to a 28-bit phase accumulator. It then adds the selected offset to the accumulator's top twelve bits. The resulting 12-bit phase addresses a quarter-wave sine table, or it forms a triangle ramp directly. The output is a 10-bit code for a DAC. A square-wave sign output comes from the accumulator's most significant bit, either directly or divided by two. With a clock of f, the output frequency is `word * f / 2^28`.

The two tuning words and the two offsets are register pairs. Software loads one member of a pair while the other is in use, then switches by pin or by control bit. This makes frequency and phase modulation possible. A synchronous accumulator clear starts the waveform at a known phase. A sleep input parks the DAC code while the sign output keeps running.

Top module: `dds_core`

## Requirements
- R1: A write with `wr_en` high loads the register chosen by `wr_addr`: 0 loads tuning word A, 1 loads tuning word B, 2 loads offset A from `wr_data[11:0]`, and 3 loads offset B from `wr_data[11:0]`.
- R2: Let F and P be the selected tuning word and offset, stable since before `acc_rst` was released. After the k-th rising edge with `acc_rst` low (k >= 2), the output phase is p = ((((k-2)*F) mod 2^28) >> 16) + P, taken mod 4096.
- R3: With `tri_mode` low, `wave_out` lies within 2 codes of 511.5 + 511.5*sin(2*pi*(p+0.5)/4096). In particular, p=0 gives 512, p=1024 gives 1023 and p=3072 gives 0.
- R4: With `tri_mode` high, `wave_out` is p[10:1] when p[11] is 0, and the bitwise inverse of p[10:1] when p[11] is 1.
- R5: The bank select chooses tuning word B when 1 and A when 0. A select change made between edges j and j+1 first changes the accumulator step at edge j+2. Writing the bank that is not selected leaves the output unchanged.
- R6: The phase select chooses offset B when 1 and offset A when 0.
- R7: With `sw_sel` high, the bank selects are taken from `sw_fsel` and `sw_psel`, and the pins `fsel_pin` and `psel_pin` have no effect.
- R8: With `sign_half` low, `sign_out` after the k-th edge with `acc_rst` low equals bit 27 of ((k-1)*F) mod 2^28.
- R9: With `sign_half` high, `sign_out` toggles once per rising edge of the accumulator MSB, so its period is twice that of the direct sign.
- R10: While `acc_rst` is held, the accumulator is cleared, `wave_out` is 512 and `sign_out` is 0 from the next edge on. After `rst_n` goes low, the outputs read 512 and 0.
- R11: While `sleep` is high, `wave_out` is 512 from the next edge on. The accumulator and `sign_out` keep advancing, so the waveform resumes at the phase R2 predicts.
- R12: The tuning word feeding the accumulator always equals the value one of the two tuning registers held on the previous cycle, so a bank switch never produces a partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| acc_rst | input | 1 | Synchronous accumulator clear, output parked while high |
| sleep | input | 1 | Parks the DAC code at mid-scale |
| fsel_pin | input | 1 | Pin selection of tuning word bank |
| psel_pin | input | 1 | Pin selection of phase offset bank |
| sw_sel | input | 1 | Take bank selects from control bits instead of pins |
| sw_fsel | input | 1 | Control-bit tuning word bank select |
| sw_psel | input | 1 | Control-bit phase offset bank select |
| tri_mode | input | 1 | 1 selects triangle output, 0 selects sine |
| sign_half | input | 1 | 1 divides the sign output by two |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index for writes |
| wr_data | input | 28 | Write data |
| wave_out | output | 10 | Waveform code to the DAC |
| sign_out | output | 1 | Square-wave sign output |

## Verification
Static tuning words of zero, combined with chosen offsets, pin the phase exactly. These cases separate the sine table's quadrant folding from the triangle's fold at each quadrant boundary.

Non-zero words are also tried:
- a small odd word, which exercises low-order carries into the top bits;
- a near-full word, which checks wrap-around modulo 2^28;
- a step that crosses the half-phase point.

Each of these compares against the closed-form phase and confirms the two-edge pipeline latency. A mid-run bank switch followed by a write to the idle bank checks whether the new word lands on the right edge and whether the idle bank is isolated. Counting sign rising edges over a fixed window distinguishes the direct sign from the halved one.

// File: rtl/dds_core.sv
module dds_core #(
  parameter int ACC_W   = 28,
  parameter int PHASE_W = 12,
  parameter int OUT_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_rst,
  input  logic               sleep,
  input  logic               fsel_pin,
  input  logic               psel_pin,
  input  logic               sw_sel,
  input  logic               sw_fsel,
  input  logic               sw_psel,
  input  logic               tri_mode,
  input  logic               sign_half,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [ACC_W-1:0]   wr_data,
  output logic [OUT_W-1:0]   wave_out,
  output logic               sign_out
);

  localparam int QW    = PHASE_W - 2;
  localparam int LUT_N = 1 << QW;
  localparam int MAG_W = OUT_W - 1;
  localparam int MID   = 1 << (OUT_W - 1);
  localparam int AMP   = MID - 1;

  // Quarter-wave magnitude at the centre of step i, rational sine approximation
  function automatic logic [MAG_W-1:0] qsin(input int i);
    longint u, d, w, num, den;
    u   = 2 * longint'(i) + 1;
    d   = longint'(1) << PHASE_W;
    w   = u * (d - u);
    num = longint'(AMP) * 16 * w;
    den = 5 * d * d - 4 * w;
    return MAG_W'((num + den / 2) / den);
  endfunction

  logic [MAG_W-1:0] rom [LUT_N];
  for (genvar g = 0; g < LUT_N; g++) begin : g_rom
    assign rom[g] = qsin(g);
  end

  logic [ACC_W-1:0]   f0_q, f1_q, fword_q, acc;
  logic [PHASE_W-1:0] p0_q, p1_q, poff_q, psum_q;
  logic [OUT_W-1:0]   wave_q;
  logic               msb_q, half_q;

  wire fsel = sw_sel ? sw_fsel : fsel_pin;
  wire psel = sw_sel ? sw_psel : psel_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f0_q <= '0;
      f1_q <= '0;
      p0_q <= '0;
      p1_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: f0_q <= wr_data;
        2'd1: f1_q <= wr_data;
        2'd2: p0_q <= wr_data[PHASE_W-1:0];
        default: p1_q <= wr_data[PHASE_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fword_q <= '0;
      poff_q  <= '0;
    end else begin
      fword_q <= fsel ? f1_q : f0_q;
      poff_q  <= psel ? p1_q : p0_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      psum_q <= '0;
      msb_q  <= 1'b0;
      half_q <= 1'b0;
    end else if (acc_rst) begin
      acc    <= '0;
      psum_q <= '0;
      msb_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      acc    <= acc + fword_q;
      psum_q <= acc[ACC_W-1 -: PHASE_W] + poff_q;
      msb_q  <= acc[ACC_W-1];
      half_q <= half_q ^ (acc[ACC_W-1] & ~msb_q);
    end
  end

  wire [QW-1:0]    qidx = psum_q[PHASE_W-2] ? ~psum_q[QW-1:0] : psum_q[QW-1:0];
  wire [MAG_W-1:0] mag  = rom[qidx];

  wire [OUT_W-1:0] sine_code = psum_q[PHASE_W-1] ? OUT_W'(AMP) - {1'b0, mag}
                                                 : OUT_W'(MID) + {1'b0, mag};
  wire [OUT_W-1:0] tri_code  = psum_q[PHASE_W-1] ? ~psum_q[PHASE_W-2:1]
                                                 :  psum_q[PHASE_W-2:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wave_q <= OUT_W'(MID);
    else if (acc_rst || sleep) wave_q <= OUT_W'(MID);
    else                       wave_q <= tri_mode ? tri_code : sine_code;
  end

  assign wave_out = wave_q;
  assign sign_out = sign_half ? half_q : msb_q;

endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk #(
  parameter int ACC_W   = 28,
  parameter int PHASE_W = 12,
  parameter int OUT_W   = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_rst,
  input logic               sleep,
  input logic               tri_mode,
  input logic               sign_half,
  input logic [OUT_W-1:0]   wave_out,
  input logic               sign_out,
  input logic [ACC_W-1:0]   fword_q,
  input logic [ACC_W-1:0]   f0_q,
  input logic [ACC_W-1:0]   f1_q,
  input logic [PHASE_W-1:0] poff_q,
  input logic               acc_msb
);

  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

  logic [2:0] up_cnt, run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 3'd7) up_cnt <= up_cnt + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (fword_q == '0 && !acc_rst && !sleep && up_cnt != '0 &&
             $stable(poff_q) && $stable(tri_mode)) begin
      if (run != 3'd7) run <= run + 3'd1;
    end else run <= '0;
  end

  // R10
  reset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rst |=> (wave_out == MID && sign_out == 1'b0));

  // R11
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> wave_out == MID);

  // R12
  bank_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_cnt != '0 |-> (fword_q == $past(f0_q) || fword_q == $past(f1_q)));

  // R2
  frozen_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run >= 3'd3 |-> $stable(wave_out));

  // R9
  half_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 3'd2 && sign_half && $past(sign_half) && !$past(acc_rst) &&
     !$stable(sign_out)) |-> $past(acc_msb));

endmodule

bind dds_core dds_core_chk #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_rst(acc_rst), .sleep(sleep),
  .tri_mode(tri_mode), .sign_half(sign_half), .wave_out(wave_out),
  .sign_out(sign_out), .fword_q(fword_q), .f0_q(f0_q), .f1_q(f1_q),
  .poff_q(poff_q), .acc_msb(acc[ACC_W-1])
);

// File: tb/dds_core_bench.sv
`timescale 1ns/100ps
module dds_core_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0, acc_rst = 1'b0, sleep = 1'b0;
  logic fsel_pin = 1'b0, psel_pin = 1'b0, sw_sel = 1'b0, sw_fsel = 1'b0, sw_psel = 1'b0;
  logic tri_mode = 1'b0, sign_half = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [27:0] wr_data = '0;
  logic [9:0]  wave_out;
  logic        sign_out;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  dds_core u_dds_core (
    .clk(clk), .rst_n(rst_n), .acc_rst(acc_rst), .sleep(sleep),
    .fsel_pin(fsel_pin), .psel_pin(psel_pin), .sw_sel(sw_sel),
    .sw_fsel(sw_fsel), .sw_psel(sw_psel), .tri_mode(tri_mode),
    .sign_half(sign_half), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wave_out(wave_out), .sign_out(sign_out)
  );

  // {tuning word, offset, mode (1 = triangle), edges after release}
  localparam logic [59:0] VEC [10] = '{
    {28'h0000000, 12'd0,    4'd0, 16'd4},
    {28'h0000000, 12'd1024, 4'd0, 16'd4},
    {28'h0000000, 12'd3072, 4'd0, 16'd4},
    {28'h0000000, 12'd2046, 4'd1, 16'd4},
    {28'h0000000, 12'd4095, 4'd1, 16'd4},
    {28'h0123457, 12'd0,    4'd0, 16'd40},
    {28'h0800000, 12'd100,  4'd1, 16'd23},
    {28'hFFFFFFF, 12'd0,    4'd1, 16'd5},
    {28'h3000001, 12'd2000, 4'd0, 16'd77},
    {28'h00FFFFF, 12'd5,    4'd1, 16'd130}
  };

  function automatic int ph(longint a, int p);
    return int'((((a & 64'hFFFFFFF) >> 16) + longint'(p)) & 64'hFFF);
  endfunction

  function automatic int tri_exp(int p);
    return (p < 2048) ? (p >> 1) : 1023 - ((p >> 1) & 1023);
  endfunction

  task automatic chk(input string tag, input int got, input int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  task automatic chk_wave(input string tag, input int p, input bit tri_m);
    if (tri_m) chk(tag, int'(wave_out), tri_exp(p));
    else begin
      real id = 511.5 + 511.5 * $sin(6.283185307179586 * (real'(p) + 0.5) / 4096.0);
      checks++;
      if (real'(wave_out) < id - 2.0 || real'(wave_out) > id + 2.0) begin
        errors++;
        $display("FAIL %s: got %0d expected about %0.1f (phase %0d)", tag, wave_out, id, p);
      end
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [27:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start(input logic [27:0] f0, input logic [27:0] f1,
                       input logic [11:0] p0, input logic [11:0] p1);
    wr(2'd0, f0); wr(2'd1, f1); wr(2'd2, {16'd0, p0}); wr(2'd3, {16'd0, p1});
    acc_rst = 1'b1;
    repeat (3) @(negedge clk);
    acc_rst = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int count_rises(input logic [64:0] s);
    int c = 0;
    for (int i = 0; i < 64; i++) if (!s[i] && s[i+1]) c++;
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [64:0] samp;
    longint a, b, f;

    // R10 reset state
    #7;
    chk("R10 rst wave", int'(wave_out), 512);
    chk("R10 rst sign", int'(sign_out), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 vector walk
    for (int v = 0; v < 10; v++) begin
      logic [27:0] fv = VEC[v][59:32];
      int pv = int'(VEC[v][31:20]);
      bit tm = VEC[v][16];
      int n = int'(VEC[v][15:0]);
      tri_mode = tm;
      start(fv, 28'h0ABCDEF, pv[11:0], 12'd777);
      edges(n);
      chk_wave($sformatf("R1 R2 %s vec%0d", tm ? "R4" : "R3", v),
               ph(longint'(n - 2) * longint'(fv), pv), tm);
    end

    // R10 held clear with a running word
    tri_mode = 1'b1;
    start(28'h0123457, 28'h0, 12'd300, 12'd0);
    edges(10);
    acc_rst = 1'b1;
    edges(4);
    chk("R10 held wave", int'(wave_out), 512);
    chk("R10 held sign", int'(sign_out), 0);
    acc_rst = 1'b0;

    // R6 phase bank by pin
    psel_pin = 1'b1;
    start(28'h0, 28'h0, 12'd500, 12'd1500);
    edges(4);
    chk_wave("R6 psel=1", 1500, 1'b1);
    psel_pin = 1'b0;
    edges(4);
    chk_wave("R6 psel=0", 500, 1'b1);

    // R7 control bits override pins
    psel_pin = 1'b1; fsel_pin = 1'b1;
    sw_sel = 1'b1; sw_psel = 1'b0; sw_fsel = 1'b0;
    start(28'h0, 28'h0400000, 12'd600, 12'd1800);
    edges(6);
    chk_wave("R7 pins ignored", 600, 1'b1);
    sw_psel = 1'b1;
    edges(4);
    chk_wave("R7 sw_psel", 1800, 1'b1);
    sw_sel = 1'b0; psel_pin = 1'b0; fsel_pin = 1'b0; sw_psel = 1'b0;

    // R5 frequency bank switch and idle-bank write
    a = 64'h0100000; b = 64'h0340000;
    start(a[27:0], b[27:0], 12'd0, 12'd0);
    edges(10);
    fsel_pin = 1'b1;
    edges(10);
    chk_wave("R5 switch", ph(11 * a + 7 * b, 0), 1'b1);
    wr(2'd0, 28'h5555555);
    edges(4);
    chk_wave("R5 idle write", ph(11 * a + 12 * b, 0), 1'b1);
    fsel_pin = 1'b0;

    // R8 direct sign
    f = 64'h2000000;
    start(f[27:0], 28'h0, 12'd0, 12'd0);
    edges(4);
    chk("R8 sign k=4", int'(sign_out), int'(((3 * f) >> 27) & 1));
    edges(1);
    chk("R8 sign k=5", int'(sign_out), int'(((4 * f) >> 27) & 1));
    edges(10);
    for (int i = 0; i < 65; i++) begin samp[i] = sign_out; @(negedge clk); end
    chk("R8 direct rises", count_rises(samp), 8);

    // R9 halved sign
    sign_half = 1'b1;
    edges(20);
    for (int i = 0; i < 65; i++) begin samp[i] = sign_out; @(negedge clk); end
    chk("R9 halved rises", count_rises(samp), 4);
    sign_half = 1'b0;

    // R11 sleep parks the code, accumulator keeps going
    f = 64'h0123457;
    tri_mode = 1'b0;
    start(f[27:0], 28'h0, 12'd0, 12'd0);
    sleep = 1'b1;
    edges(10);
    chk("R11 sleep wave", int'(wave_out), 512);
    chk("R11 sleep sign", int'(sign_out), int'(((9 * f) >> 27) & 1));
    sleep = 1'b0;
    edges(20);
    chk_wave("R11 resume", ph(28 * f, 0), 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule